// File: doc/BRIEF.md
# 64B/66B Frame-to-Block Packer

This block sits on the transmit side of a single-lane serial link that uses 64-bit user words. It takes frames from a word-wide framed stream with start-of-frame, end-of-frame and byte-count marks, and turns them into 66-bit line blocks. Each block is a 2-bit sync header plus a 64-bit payload. Every full word in the middle of a frame leaves as a data block. The last word of a frame leaves as a closing control block: a short separator when it holds up to six octets, or a seven-octet separator when it holds exactly seven.

A last word that is completely full cannot fit inside either closing block. It is sent as a data block, followed by a separator whose octet count is zero. While that extra block waits for the output, the packer holds its input ready low, so no user word is lost. Scrambling, the gearbox, clock compensation and flow-control insertion belong to neighbouring blocks.

The output is a single registered stage with valid/ready handshaking. A block offered downstream stays unchanged until the downstream side takes it.

Top module: `blk64_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted word that belongs to a frame and does not carry `in_eof` produces one data block: sync `2'b01`, and the payload equals the word bit for bit. Octet k of any word is `in_data[8k+7:8k]`, and octet 0 is the first octet on the line.
- R3: A frame's last word with a byte count n from 1 to 6 produces one separator block with sync `2'b10`. Payload byte 0 is the type value `8'h1E` and payload byte 1 is n. Octet k of the word, for k < n, sits in payload byte k+2. Every other payload byte is zero. (Payload byte j is `out_payload[8j+7:8j]`.)
- R4: A frame's last word with a byte count of 7 produces one seven-octet separator with sync `2'b10`. Payload byte 0 is the parameter `SEP7_TYPE` (default `8'hE1`), and octet k sits in payload byte k+1, for k from 0 to 6.
- R5: A frame's last word with a byte count of 8, or with a byte count of 0 or above 8 (both treated as 8), produces a data block holding the word. It is followed by a separator block with count 0 and a zero payload apart from the type byte. During the cycle after that word is accepted, `in_ready` is 0.
- R6: A word accepted while no frame is open and without `in_sof` is discarded and produces no block.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and leaves `out_sync` and `out_payload` unchanged. Blocks leave in the order of the words that produced them.
- R8: A word that carries both `in_sof` and `in_eof` forms a whole frame on its own. Frames may follow each other with no gap, and each new frame starts at the block after the previous frame's separator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | User word; octet k in bits 8k+7:8k |
| in_sof | input | 1 | Word opens a frame |
| in_eof | input | 1 | Word closes a frame |
| in_nbytes | input | 4 | Valid octets in an end word (1..8; 0 or above 8 counts as 8) |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Packer accepts the offered word |
| out_sync | output | 2 | Sync header of the block |
| out_payload | output | 64 | Block payload |
| out_valid | output | 1 | Block offered downstream |
| out_ready | input | 1 | Downstream takes the block |

## Verification
The bench builds the packer with its default parameters: a seven-octet separator type of `8'hE1` and the fixed one-lane, 64-bit word. With these values, every tail size from 0 to 8 octets can be reached inside a short run, including the stall for the zero-count separator. The bench runs two downstream phases. In the first, `out_ready` is held high. In the second, `out_ready` follows a pseudo-random pattern, so back-to-back frames are sent while the held output block and the pending extra separator overlap with downstream stalls.

// File: rtl/blk64_pkg.sv
package blk64_pkg;

    localparam int OCTETS  = 8;
    localparam int WORD_W  = OCTETS * 8;
    localparam int CNT_W   = 4;
    localparam int SEP_MAX = OCTETS - 2;

    localparam logic [1:0] SH_DATA  = 2'b01;
    localparam logic [1:0] SH_CTRL  = 2'b10;
    localparam logic [7:0] SEP_TYPE = 8'h1E;

    typedef struct packed {
        logic [1:0]        sync;
        logic [WORD_W-1:0] payload;
    } line_blk_t;

    typedef enum logic [1:0] {
        TAIL_SHORT = 2'd0,
        TAIL_SEVEN = 2'd1,
        TAIL_FULL  = 2'd2
    } tail_kind_e;

    // A count of zero or above the word size is taken as a full word.
    function automatic logic [CNT_W-1:0] norm_count(input logic [CNT_W-1:0] n);
        if (n == '0 || n > CNT_W'(OCTETS))
            return CNT_W'(OCTETS);
        return n;
    endfunction

    function automatic tail_kind_e classify(input logic [CNT_W-1:0] n);
        if (n <= CNT_W'(SEP_MAX))
            return TAIL_SHORT;
        if (n == CNT_W'(OCTETS - 1))
            return TAIL_SEVEN;
        return TAIL_FULL;
    endfunction

    function automatic line_blk_t mk_data(input logic [WORD_W-1:0] w);
        line_blk_t b;
        b.sync    = SH_DATA;
        b.payload = w;
        return b;
    endfunction

    function automatic line_blk_t mk_sep(input logic [WORD_W-1:0] w,
                                         input logic [CNT_W-1:0]  cnt);
        line_blk_t b;
        b.sync         = SH_CTRL;
        b.payload      = '0;
        b.payload[7:0] = SEP_TYPE;
        b.payload[15:8] = 8'(cnt);
        for (int k = 0; k < SEP_MAX; k++) begin
            if (CNT_W'(k) < cnt)
                b.payload[8*(k+2) +: 8] = w[8*k +: 8];
        end
        return b;
    endfunction

    function automatic line_blk_t mk_sep7(input logic [WORD_W-1:0] w,
                                          input logic [7:0]        typ);
        line_blk_t b;
        b.sync         = SH_CTRL;
        b.payload      = '0;
        b.payload[7:0] = typ;
        for (int k = 0; k < OCTETS - 1; k++)
            b.payload[8*(k+1) +: 8] = w[8*k +: 8];
        return b;
    endfunction

endpackage

// File: rtl/blk64_frame_track.sv
module blk64_frame_track
    import blk64_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic sof,
    input  logic eof,
    output logic keep
);

    logic open_q;

    // A word belongs to a frame if one is open or the word opens one.
    assign keep = open_q || sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (take && keep) begin
            open_q <= !eof;
        end
    end

endmodule

// File: rtl/blk64_former.sv
module blk64_former
    import blk64_pkg::*;
#(
    parameter logic [7:0] SEP7_TYPE = 8'hE1
)(
    input  logic [WORD_W-1:0] word,
    input  logic              eof,
    input  logic [CNT_W-1:0]  nbytes,
    output line_blk_t         blk,
    output logic              extra
);

    logic [CNT_W-1:0] cnt;
    tail_kind_e       kind;

    assign cnt  = norm_count(nbytes);
    assign kind = classify(cnt);

    always_comb begin
        blk   = mk_data(word);
        extra = 1'b0;
        if (eof) begin
            unique case (kind)
                TAIL_SHORT: blk = mk_sep(word, cnt);
                TAIL_SEVEN: blk = mk_sep7(word, SEP7_TYPE);
                default: begin
                    blk   = mk_data(word);
                    extra = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/blk64_out_stage.sv
module blk64_out_stage
    import blk64_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  line_blk_t load_blk,
    input  logic      load_extra,
    input  logic      out_ready,
    output logic      out_valid,
    output line_blk_t out_blk,
    output logic      can_take
);

    logic      vld_q;
    logic      pend_q;
    line_blk_t blk_q;
    line_blk_t sep_zero;

    assign sep_zero  = mk_sep('0, '0);
    assign can_take  = !pend_q && (!vld_q || out_ready);
    assign out_valid = vld_q;
    assign out_blk   = blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            pend_q <= 1'b0;
            blk_q  <= '0;
        end else if (vld_q && out_ready && pend_q) begin
            blk_q  <= sep_zero;
            pend_q <= 1'b0;
        end else if (load) begin
            vld_q  <= 1'b1;
            blk_q  <= load_blk;
            pend_q <= load_extra;
        end else if (out_ready) begin
            vld_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/blk64_packer.sv
module blk64_packer
    import blk64_pkg::*;
#(
    parameter logic [7:0] SEP7_TYPE = 8'hE1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [CNT_W-1:0]  in_nbytes,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [1:0]        out_sync,
    output logic [WORD_W-1:0] out_payload,
    output logic              out_valid,
    input  logic              out_ready
);

    logic      take;
    logic      keep;
    logic      can_take;
    logic      extra;
    line_blk_t formed;
    line_blk_t held;

    assign in_ready = can_take;
    assign take     = in_valid && can_take;

    blk64_frame_track u_track (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .sof  (in_sof),
        .eof  (in_eof),
        .keep (keep)
    );

    blk64_former #(.SEP7_TYPE(SEP7_TYPE)) u_form (
        .word   (in_data),
        .eof    (in_eof),
        .nbytes (in_nbytes),
        .blk    (formed),
        .extra  (extra)
    );

    blk64_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (take && keep),
        .load_blk   (formed),
        .load_extra (extra),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_blk    (held),
        .can_take   (can_take)
    );

    assign out_sync    = held.sync;
    assign out_payload = held.payload;

endmodule

// File: rtl/blk64_packer_chk.sv
module blk64_packer_chk
    import blk64_pkg::*;
#(
    parameter logic [7:0] SEP7_TYPE = 8'hE1
)(
    input logic              clk,
    input logic              rst,
    input logic              in_sof,
    input logic              in_eof,
    input logic [CNT_W-1:0]  in_nbytes,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        out_sync,
    input logic [WORD_W-1:0] out_payload,
    input logic              out_valid,
    input logic              out_ready
);

    logic full_tail;
    assign full_tail = (in_nbytes == '0) || (in_nbytes >= CNT_W'(OCTETS));

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R7
    hold_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sync) && $stable(out_payload)));

    // R5
    extra_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_sof && in_eof && full_tail) |=> !in_ready);

    // R2
    sync_legal_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sync == SH_DATA || out_sync == SH_CTRL));

    // R3
    sep_count_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sync == SH_CTRL && out_payload[7:0] == SEP_TYPE)
            |-> (out_payload[15:8] <= 8'(SEP_MAX)));

    // R4
    ctrl_type_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sync == SH_CTRL)
            |-> (out_payload[7:0] == SEP_TYPE || out_payload[7:0] == SEP7_TYPE));

endmodule

bind blk64_packer blk64_packer_chk #(.SEP7_TYPE(SEP7_TYPE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .in_nbytes   (in_nbytes),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_sync    (out_sync),
    .out_payload (out_payload),
    .out_valid   (out_valid),
    .out_ready   (out_ready)
);

// File: tb/test_blk64_packer.sv
`timescale 1ns/1ps
module test_blk64_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [3:0]  in_nbytes = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  out_sync;
    logic [63:0] out_payload;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int fires   = 0;
    int pushes  = 0;
    bit rnd_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [65:0] exp_q[$];
    string       tag_q[$];
    bit          frame_open = 1'b0;
    bit          hold_prev = 1'b0;
    logic [65:0] held_val;
    bit          pend_chk = 1'b0;

    always #4 clk = ~clk;

    blk64_packer i_blk64_packer (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_nbytes(in_nbytes), .in_valid(in_valid), .in_ready(in_ready),
        .out_sync(out_sync), .out_payload(out_payload), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    function automatic logic [63:0] word_of(input int i);
        return {32'(i * 32'h9E3779B9), 32'((i + 7) * 32'h85EBCA6B) ^ 32'h5BD1E995};
    endfunction

    function automatic logic [65:0] exp_sep(input logic [63:0] d, input int c);
        logic [63:0] p = '0;
        p[7:0]  = 8'h1E;
        p[15:8] = 8'(c);
        for (int k = 0; k < c; k++) p[8*(k+2) +: 8] = d[8*k +: 8];
        return {2'b10, p};
    endfunction

    function automatic logic [65:0] exp_sep7(input logic [63:0] d);
        logic [63:0] p = '0;
        p[7:0] = 8'hE1;
        for (int k = 0; k < 7; k++) p[8*(k+1) +: 8] = d[8*k +: 8];
        return {2'b10, p};
    endfunction

    task automatic check(input bit ok, input string req, input logic [65:0] act,
                         input logic [65:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: returns 1 when a zero-count separator must follow.
    function automatic bit model_take(input logic [63:0] d, input bit s, input bit e,
                                      input int n);
        int nn;
        if (!(frame_open || s)) return 1'b0;           // R6 discarded
        frame_open = !e;
        if (!e) begin
            exp_q.push_back({2'b01, d}); tag_q.push_back("R2"); pushes++;
            return 1'b0;
        end
        nn = (n == 0 || n > 8) ? 8 : n;
        if (nn <= 6) begin
            exp_q.push_back(exp_sep(d, nn)); tag_q.push_back((s) ? "R8" : "R3"); pushes++;
            return 1'b0;
        end
        if (nn == 7) begin
            exp_q.push_back(exp_sep7(d)); tag_q.push_back("R4"); pushes++;
            return 1'b0;
        end
        exp_q.push_back({2'b01, d});          tag_q.push_back("R5"); pushes++;
        exp_q.push_back(exp_sep(64'h0, 0));   tag_q.push_back("R5"); pushes++;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= rnd_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (hold_prev)
                check(out_valid && {out_sync, out_payload} == held_val, "R7 held block",
                      {out_sync, out_payload}, held_val);
            if (pend_chk)
                check(!in_ready, "R5 in_ready low", {65'h0, in_ready}, 66'h0);
            pend_chk = 1'b0;
            if (out_valid && out_ready) begin
                fires++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected block", {out_sync, out_payload}, 66'h0);
                end else begin
                    automatic logic [65:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check({out_sync, out_payload} == e, t, {out_sync, out_payload}, e);
                end
            end
            hold_prev = out_valid && !out_ready;
            held_val  = {out_sync, out_payload};
            if (in_valid && in_ready)
                pend_chk = model_take(in_data, in_sof, in_eof, int'(in_nbytes)) &&
                           (in_eof && (in_sof || 1'b1));
            if (cyc > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    task automatic send(input logic [63:0] d, input bit s, input bit e, input int n);
        in_data = d; in_sof = s; in_eof = e; in_nbytes = 4'(n); in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #2;
    endtask

    task automatic frame(input int len, input int tail, input int base);
        for (int i = 0; i < len; i++)
            send(word_of(base + i), i == 0, i == len - 1, (i == len - 1) ? tail : 8);
    endtask

    task automatic drain();
        in_valid = 1'b0;
        for (int i = 0; i < 40; i++) @(posedge clk);
        #2;
    endtask

    int base = 1;

    initial begin
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 reset state", {64'h0, out_valid, in_ready},
              {64'h0, 2'b01});
        @(posedge clk); #2;

        // Main function, downstream always ready
        frame(3, 5, base); base += 10;
        for (int t = 1; t <= 8; t++) begin
            frame(2, t, base); base += 10;
        end
        // R8 back-to-back single-word frames
        send(word_of(base), 1, 1, 3); send(word_of(base + 1), 1, 1, 6);
        send(word_of(base + 2), 1, 1, 7); send(word_of(base + 3), 1, 1, 8);
        send(word_of(base + 4), 1, 1, 1); base += 10;
        // R5 count 0 and 9 treated as full word
        frame(1, 0, base); frame(2, 9, base + 3); base += 10;
        // R6 orphan words outside any frame
        send(word_of(base), 0, 0, 8); send(word_of(base + 1), 0, 1, 4);
        frame(2, 2, base + 2); base += 10;
        drain();
        check(fires == pushes && exp_q.size() == 0, "R6 block count",
              66'(fires), 66'(pushes));

        // Downstream stalls
        rnd_mode = 1'b1;
        for (int f = 0; f < 60; f++) begin
            frame(1 + (f % 4), f % 10, base); base += 10;
            if (f % 7 == 3) send(word_of(base), 0, 1, 5);
        end
        rnd_mode = 1'b0;
        drain();
        check(fires == pushes && exp_q.size() == 0, "R7 order and count",
              66'(fires), 66'(pushes));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule